// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one single-rank SDR SDRAM between reset and the moment the memory can take normal traffic. After reset is released it raises the clock enable and holds a NOP on the bus for a power-up interval. It then precharges every bank, runs two auto-refresh cycles and writes a caller-supplied value into the mode register. Once the last wait expires, it raises a ready level that a normal controller uses to take over the bus.

Every gap between commands is a parameter in nanoseconds. It is turned into a clock count at elaboration from the clock period, and no gap is shorter than one cycle. One parameter sets whether the mode register is written after the two refreshes or straight after the precharge. All outputs come from registers, so the pins change only on clock edges.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs after that edge are `cke`=0, {`cs_n`,`ras_n`,`cas_n`,`we_n`}=1111, `addr`=0, `ba`=0, `dqm` all ones and `init_done`=0. This holds from any point in the sequence.
- R2: After reset is released, the first N_PU cycles show `cke`=1 with a NOP ({cs,ras,cas,we}=0111). N_PU is the power-up gap.
- R3: The first command is precharge-all: encoding 0010, `addr` bit 10 set, all other `addr` bits 0 and `ba`=0.
- R4: The next command follows the precharge exactly N_RP cycles later, with NOP and `addr`=0 in the cycles between.
- R5: There are two auto-refresh commands (encoding 0001, `addr`=0, `ba`=0). Each one opens a window of N_RFC cycles that holds NOP after the command cycle.
- R6: The load-mode command has encoding 0000, puts `mode_code` on `addr` and sets `ba`=0.
- R7: The load-mode command opens a window of N_MRD = max(T_MRD_CYC,1) cycles. The next command or the ready level comes N_MRD cycles later.
- R8: With MODE_FIRST=0 the order is precharge, refresh, refresh, load-mode. With MODE_FIRST=1 it is precharge, load-mode, refresh, refresh.
- R9: `dqm` is all ones in every cycle, in reset and out of it.
- R10: Each gap in cycles is max(1, ceil(t_ns*1000 / CLK_PERIOD_PS)). A gap of one cycle puts two commands on consecutive cycles.
- R11: `init_done` rises in the cycle after the last window ends. It then stays high with a NOP on the bus until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | ADDR_W | Value written to the mode register |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BA_W | Bank address |
| dqm | output | DQM_W | Data mask, held high |
| init_done | output | 1 | Sequence complete, bus may be handed over |

## Verification
The bench builds two instances side by side, both with a 200 ns power-up.
- The first uses the late mode-register order with 20 ns and 70 ns gaps. These round up to 3 and 9 cycles at 8 ns.
- The second uses the early order, a zero-nanosecond precharge gap and a one-cycle mode gap. This puts precharge, load-mode and refresh on consecutive cycles and exercises the one-cycle floor.
- Its 64 ns refresh gap divides the period exactly, which catches over-rounding.

A reset in mid-sequence, with a new mode code applied afterwards, shows the restart from power-up wait.

// File: rtl/sdram_boot_pkg.sv
`timescale 1ns/1ps
// Package: shared step type, command encodings and gap arithmetic for the
// power-up sequencer. Assumes t_ns*1000 fits in 32 bits (t_ns < 4.2 ms).
package sdram_boot_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_PRE,
        ST_REF1,
        ST_REF2,
        ST_LMR,
        ST_DONE
    } step_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_DESEL = 4'b1111;
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_PRE   = 4'b0010;
    localparam logic [3:0] CMD_REF   = 4'b0001;
    localparam logic [3:0] CMD_LMR   = 4'b0000;

    // Converts a nanosecond interval into whole cycles, rounded up, floor of 1.
    function automatic int unsigned gap_cycles(input int unsigned t_ns,
                                               input int unsigned per_ps);
        int unsigned c;
        c = (t_ns * 1000 + per_ps - 1) / per_ps;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boot_timer.sv
`timescale 1ns/1ps
// Module: boot_timer
// Down-counter that measures the length of one sequencer step. Reset loads
// RST_VAL so the power-up window starts counting at once. A load takes
// priority over counting. The counter holds at zero until the next load.
// Assumes load values fit in CW bits.
module boot_timer #(
    parameter int unsigned CW      = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    // Count down the current window, or reload it for the next step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CW'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The window has ended once the count reaches zero.
    always_comb zero = (cnt == '0);

endmodule

// File: rtl/boot_step_fsm.sv
`timescale 1ns/1ps
// Module: boot_step_fsm
// Walks the initialization steps. Each step lasts exactly its gap in
// cycles. 'first' marks the opening cycle of a step, the only cycle in
// which that step's command goes out. The MODE_FIRST parameter picks where
// the mode-register step sits in the order. Assumes every gap is >= 1.
module boot_step_fsm
    import sdram_boot_pkg::*;
#(
    parameter bit          MODE_FIRST = 1'b0,
    parameter int unsigned CW         = 8,
    parameter int unsigned N_RP       = 1,
    parameter int unsigned N_RFC      = 1,
    parameter int unsigned N_MRD      = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_zero,
    output step_e         step,
    output logic          first,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);

    step_e nxt;
    logic  advance;

    // Step order; the generate branch fixes where the mode load sits.
    generate
        if (MODE_FIRST) begin : g_mode_early
            always_comb begin
                unique case (step)
                    ST_PWRUP: nxt = ST_PRE;
                    ST_PRE:   nxt = ST_LMR;
                    ST_LMR:   nxt = ST_REF1;
                    ST_REF1:  nxt = ST_REF2;
                    default:  nxt = ST_DONE;
                endcase
            end
        end else begin : g_mode_late
            always_comb begin
                unique case (step)
                    ST_PWRUP: nxt = ST_PRE;
                    ST_PRE:   nxt = ST_REF1;
                    ST_REF1:  nxt = ST_REF2;
                    ST_REF2:  nxt = ST_LMR;
                    default:  nxt = ST_DONE;
                endcase
            end
        end
    endgenerate

    // Move on when the current window has ended, unless already finished.
    always_comb advance = tmr_zero && (step != ST_DONE);

    // Reload the timer with the length, minus one, of the step being entered.
    always_comb begin
        tmr_load = advance;
        unique case (nxt)
            ST_PRE:           tmr_val = CW'(N_RP - 1);
            ST_REF1, ST_REF2: tmr_val = CW'(N_RFC - 1);
            ST_LMR:           tmr_val = CW'(N_MRD - 1);
            default:          tmr_val = '0;
        endcase
    end

    // Step register and opening-cycle marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= ST_PWRUP;
            first <= 1'b0;
        end else if (advance) begin
            step  <= nxt;
            first <= 1'b1;
        end else begin
            first <= 1'b0;
        end
    end

endmodule

// File: rtl/boot_cmd_drive.sv
`timescale 1ns/1ps
// Module: boot_cmd_drive
// Turns the current step into pin values and registers them, so every
// output changes only on a clock edge. A command goes out only in the
// opening cycle of its step; all other cycles carry NOP. Assumes
// ADDR_W > 10, since bit 10 selects all banks on precharge.
module boot_cmd_drive
    import sdram_boot_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned DQM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             step,
    input  logic              first,
    input  logic [ADDR_W-1:0] mode_code,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [DQM_W-1:0]  dqm,
    output logic              init_done
);

    localparam int unsigned ALL_BANKS_BIT = 10;

    logic [3:0]        cmd_d;
    logic [ADDR_W-1:0] addr_d;

    // Pick the command and address for the cycle being entered.
    always_comb begin
        cmd_d  = CMD_NOP;
        addr_d = '0;
        if (first) begin
            unique case (step)
                ST_PRE: begin
                    cmd_d                 = CMD_PRE;
                    addr_d[ALL_BANKS_BIT] = 1'b1;
                end
                ST_REF1, ST_REF2: cmd_d = CMD_REF;
                ST_LMR: begin
                    cmd_d  = CMD_LMR;
                    addr_d = mode_code;
                end
                default: cmd_d = CMD_NOP;
            endcase
        end
    end

    // Output register: deselected and masked in reset, clock enabled after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke       <= 1'b0;
            cmd       <= CMD_DESEL;
            addr      <= '0;
            ba        <= '0;
            dqm       <= '1;
            init_done <= 1'b0;
        end else begin
            cke       <= 1'b1;
            cmd       <= cmd_d;
            addr      <= addr_d;
            ba        <= '0;
            dqm       <= '1;
            init_done <= (step == ST_DONE);
        end
    end

endmodule

// File: rtl/sdram_boot_seq.sv
`timescale 1ns/1ps
// Module: sdram_boot_seq (top)
// SDR SDRAM power-up sequencer. The steps are the power-up wait, a
// precharge of all banks, two auto-refresh commands and a mode-register
// load, in the order MODE_FIRST selects, then a ready level. All gaps come
// from nanosecond parameters and the clock period at elaboration.
// Assumes a single rank and a clock that is stable before reset is released.
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned T_PWRUP_NS    = 100000,
    parameter int unsigned T_RP_NS       = 20,
    parameter int unsigned T_RFC_NS      = 70,
    parameter int unsigned T_MRD_CYC     = 2,
    parameter bit          MODE_FIRST    = 1'b0,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned DQM_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_code,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic [DQM_W-1:0]  dqm,
    output logic              init_done
);

    localparam int unsigned N_PU  = gap_cycles(T_PWRUP_NS, CLK_PERIOD_PS);
    localparam int unsigned N_RP  = gap_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned N_RFC = gap_cycles(T_RFC_NS, CLK_PERIOD_PS);
    localparam int unsigned N_MRD = max2(T_MRD_CYC, 1);
    localparam int unsigned N_MAX = max2(max2(N_PU, N_RP), max2(N_RFC, N_MRD));
    localparam int unsigned CW    = max2($clog2(N_MAX), 1);

    step_e         step;
    logic          first;
    logic          tmr_load;
    logic          tmr_zero;
    logic [CW-1:0] tmr_val;
    logic [3:0]    cmd;

    boot_timer #(
        .CW      (CW),
        .RST_VAL (N_PU - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    boot_step_fsm #(
        .MODE_FIRST (MODE_FIRST),
        .CW         (CW),
        .N_RP       (N_RP),
        .N_RFC      (N_RFC),
        .N_MRD      (N_MRD)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_zero (tmr_zero),
        .step     (step),
        .first    (first),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    boot_cmd_drive #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .DQM_W  (DQM_W)
    ) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .first     (first),
        .mode_code (mode_code),
        .cke       (cke),
        .cmd       (cmd),
        .addr      (addr),
        .ba        (ba),
        .dqm       (dqm),
        .init_done (init_done)
    );

    // Split the registered command into the four strobe pins.
    always_comb {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_boot_chk.sv
`timescale 1ns/1ps
// Module: sdram_boot_chk
// Protocol checks on the pins of sdram_boot_seq, attached with bind.
// Assumes ADDR_W > 10.
module sdram_boot_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2,
    parameter int unsigned N_MRD  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mode_code,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              init_done
);

    logic [3:0] pins;
    always_comb pins = {cs_n, ras_n, cas_n, we_n};

    // R1
    reset_pins_chk: assert property (@(posedge clk)
        !rst_n |=> (!cke && pins == 4'b1111 && !init_done));

    // R2
    cke_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cke);

    // R3
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0010) |-> (addr[10] && ba == '0));

    // R6
    lmr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == 4'b0000) |-> (addr == mode_code && ba == '0));

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pins == 4'b0111));

    generate
        if (N_MRD > 1) begin : g_mrd
            // R7
            lmr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pins == 4'b0000) |=> (pins == 4'b0111));
        end
    endgenerate

endmodule

bind sdram_boot_seq sdram_boot_chk #(
    .ADDR_W (ADDR_W),
    .BA_W   (BA_W),
    .N_MRD  (N_MRD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_code (mode_code),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
);

// File: tb/sim_sdram_boot_seq.sv
`timescale 1ns/1ps
// Bench: two sequencer instances checked every cycle against a behavioural
// slot model built from the requirements.
module sim_sdram_boot_seq;

    localparam int PER_PS = 8000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] mc0 = 12'h032;
    logic [11:0] mc1 = 12'h027;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;
    int slot0 = 0;
    int slot1 = 0;

    always #4 clk = ~clk;

    logic cke0, cs0, ras0, cas0, we0, dn0;
    logic [11:0] ad0;
    logic [1:0] ba0, dq0;
    logic cke1, cs1, ras1, cas1, we1, dn1;
    logic [11:0] ad1;
    logic [1:0] ba1, dq1;

    sdram_boot_seq #(
        .CLK_PERIOD_PS(PER_PS), .T_PWRUP_NS(200), .T_RP_NS(20), .T_RFC_NS(70),
        .T_MRD_CYC(2), .MODE_FIRST(1'b0), .ADDR_W(12), .BA_W(2), .DQM_W(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_code(mc0), .cke(cke0), .cs_n(cs0),
        .ras_n(ras0), .cas_n(cas0), .we_n(we0), .addr(ad0), .ba(ba0),
        .dqm(dq0), .init_done(dn0)
    );

    sdram_boot_seq #(
        .CLK_PERIOD_PS(PER_PS), .T_PWRUP_NS(200), .T_RP_NS(0), .T_RFC_NS(64),
        .T_MRD_CYC(1), .MODE_FIRST(1'b1), .ADDR_W(12), .BA_W(2), .DQM_W(2)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .mode_code(mc1), .cke(cke1), .cs_n(cs1),
        .ras_n(ras1), .cas_n(cas1), .we_n(we1), .addr(ad1), .ba(ba1),
        .dqm(dq1), .init_done(dn1)
    );

    // R10: gap rule, written independently of the design.
    function automatic int bgap(input int t_ns);
        int c;
        c = (t_ns * 1000 + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected {cke, cmd, addr, ba, dqm, done} in a given slot after reset release.
    function automatic logic [21:0] model(input bit mf, input int npu, input int nrp,
                                          input int nrfc, input int nmrd,
                                          input logic [11:0] mc, input int slot,
                                          output string tag);
        int kind[4];
        int len[4];
        int pos;
        logic [21:0] nop;
        nop = {1'b1, 4'b0111, 12'h000, 2'b00, 2'b11, 1'b0};
        if (slot == 0) begin
            tag = "R1 R9";
            return {1'b0, 4'b1111, 12'h000, 2'b00, 2'b11, 1'b0};
        end
        if (mf) kind = '{1, 3, 2, 2};
        else    kind = '{1, 2, 2, 3};
        for (int k = 0; k < 4; k++)
            len[k] = (kind[k] == 1) ? nrp : (kind[k] == 2) ? nrfc : nmrd;
        if (slot <= npu) begin
            tag = "R2 R9";
            return nop;
        end
        pos = npu;
        for (int k = 0; k < 4; k++) begin
            if (slot == pos + 1) begin
                if (kind[k] == 1) begin
                    tag = "R3 R8";
                    return {1'b1, 4'b0010, 12'h400, 2'b00, 2'b11, 1'b0};
                end else if (kind[k] == 2) begin
                    tag = "R5 R8";
                    return {1'b1, 4'b0001, 12'h000, 2'b00, 2'b11, 1'b0};
                end else begin
                    tag = "R6 R8";
                    return {1'b1, 4'b0000, mc, 2'b00, 2'b11, 1'b0};
                end
            end
            if (slot <= pos + len[k]) begin
                tag = (kind[k] == 1) ? "R4 R10" : (kind[k] == 2) ? "R5 R10" : "R7";
                return nop;
            end
            pos += len[k];
        end
        tag = "R11";
        return {1'b1, 4'b0111, 12'h000, 2'b00, 2'b11, 1'b1};
    endfunction

    // Slot counters: zero in reset, one more per edge after release.
    always @(posedge clk) begin
        started <= 1'b1;
        slot0 <= rst_n ? slot0 + 1 : 0;
        slot1 <= rst_n ? slot1 + 1 : 0;
    end

    // Compare both instances once per cycle, away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            string t0, t1;
            logic [21:0] e0, e1, a0, a1;
            e0 = model(1'b0, bgap(200), bgap(20), bgap(70), 2, mc0, slot0, t0);
            e1 = model(1'b1, bgap(200), bgap(0), bgap(64), 1, mc1, slot1, t1);
            a0 = {cke0, cs0, ras0, cas0, we0, ad0, ba0, dq0, dn0};
            a1 = {cke1, cs1, ras1, cas1, we1, ad1, ba1, dq1, dn1};
            checks += 2;
            if (a0 !== e0) begin
                errors++;
                $display("FAIL %s u0 slot %0d act=%h exp=%h", t0, slot0, a0, e0);
            end
            if (a1 !== e1) begin
                errors++;
                $display("FAIL %s u1 slot %0d act=%h exp=%h", t1, slot1, a1, e1);
            end
        end
    end

    // Stimulus: full run, reset mid-sequence with new codes, then a second run.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (33) @(posedge clk);
        #1 rst_n = 1'b0;       // R1: mid-sequence reset
        mc0 = 12'h5A3;
        mc1 = 12'h3FF;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (70) @(posedge clk);
        #2 finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule